// File: doc/BRIEF.md
# Hysteretic Step-Down Switch Controller

This block is the digital core of a hysteretic step-down converter. On every clock it reads three comparator results that arrive already synchronised: the output is below its regulation threshold, the high-side current is above its limit, and the inductor current has fallen to the rectifier cut-off level. It also reads an enable and a thermal trip and cooled pair. From these it drives the high-side and low-side gate enables and a request to float the switch node.

A conduction pulse starts when the output sags and the minimum off interval has run. The pulse ends once the minimum on interval has run and the output is back in regulation. An over-current ends it at once, even before the minimum on interval has run. Between pulses the synchronous rectifier conducts until the inductor current reaches the cut-off level. The rectifier also releases one cycle before the next pulse, so the two gates are never high in the same cycle and each change of side has a dead cycle. When disabled or over-temperature, the block floats the switch node. After a thermal trip it stays off until the cooled input is seen. A sustained overload therefore gives a pulsed output.

Top module: `hyst_buck_ctrl`

## Requirements
- R1: After reset, `sw_hiz` is 1 and both `hs_gate` and `ls_gate` are 0.
- R2: `hs_gate` and `ls_gate` are never 1 in the same cycle. Each change of conducting side passes through at least one cycle with both gates at 0.
- R3: Between two high-side pulses with no float in between, `hs_gate` stays 0 for at least MIN_OFF_CYC+1 cycles. A pulse begins two cycles after a sample with `below_reg`=1 taken once that interval has run.
- R4: A high-side pulse lasts at least MIN_ON_CYC cycles unless it is ended by the current limit or by a halt. It ends the cycle after a sample with `below_reg`=0 taken once MIN_ON_CYC has run.
- R5: `hs_over_limit`=1 sampled while `hs_gate` is 1 makes `hs_gate` 0 in the next cycle, whatever the on-time so far.
- R6: In the off phase, `ls_gate` is 0 in the first cycle after the high side turns off and 1 from the second cycle. It falls in the cycle after `il_zero_cross`=1 is sampled and stays 0 until the next high-side pulse.
- R7: `ls_gate` is 0 in the cycle immediately before every rising edge of `hs_gate`.
- R8: `enable`=0 sampled makes the next cycle show `sw_hiz`=1 with both gates 0. When `enable` returns, the first cycle after leaving float has `sw_hiz`=0 with both gates 0, and an off phase follows.
- R9: `thermal_trip`=1 sampled forces float from the next cycle. Float holds until `thermal_cooled`=1 is sampled with `thermal_trip`=0. Switching resumes two cycles after that sample.
- R10: `thermal_cooled` has no effect while no thermal fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable, 1 = switching allowed |
| below_reg | input | 1 | Output below regulation threshold |
| hs_over_limit | input | 1 | High-side current above limit |
| il_zero_cross | input | 1 | Inductor current at rectifier cut-off level |
| thermal_trip | input | 1 | Junction over-temperature |
| thermal_cooled | input | 1 | Junction has cooled by the hysteresis margin |
| hs_gate | output | 1 | High-side switch gate enable |
| ls_gate | output | 1 | Low-side rectifier gate enable |
| sw_hiz | output | 1 | Request to float the switch node |

## Verification
The assertions treat all six control inputs as synchronous to `clk` and valid at every rising edge. The minimum-time assertions also assume the parameters are at least 1 for the on interval and at least 2 for the off interval. The bench changes inputs only just after a rising edge, so every input is stable for a full cycle. It keeps the parameters at their defaults. Its random stretch raises over-current and thermal trip only rarely, so long unbroken pulse and gap runs still occur for the run-length checks.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  typedef enum logic [2:0] {
    PH_HIZ     = 3'd0,
    PH_ON      = 3'd1,
    PH_GAP_OFF = 3'd2,
    PH_OFF     = 3'd3,
    PH_GAP_ON  = 3'd4
  } hbc_phase_e;

  function automatic logic interval_done(input int unsigned elapsed,
                                         input int unsigned minimum);
    return elapsed >= minimum;
  endfunction

  function automatic int unsigned larger(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic next_fault(input logic cur, input logic trip,
                                      input logic cooled);
    if (trip) return 1'b1;
    if (cooled) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/hbc_phase_timer.sv
module hbc_phase_timer #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned SAT_VAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (restart)      count <= CNT_W'(1);
    else if (count < SAT)  count <= count + CNT_W'(1);
  end

  // R3 R4: every phase interval is measured from one
  a_r4_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == CNT_W'(1)));

endmodule

// File: rtl/hbc_thermal_guard.sv
module hbc_thermal_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic thermal_trip,
  input  logic thermal_cooled,
  output logic fault_q
);
  import hbc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= next_fault(fault_q, thermal_trip, thermal_cooled);
  end

  a_r9_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_trip |=> fault_q);

  a_r9_hold_until_cooled: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !thermal_cooled) |=> fault_q);

endmodule

// File: rtl/hbc_phase_fsm.sv
module hbc_phase_fsm #(
  parameter int unsigned MIN_ON_CYC  = 4,
  parameter int unsigned MIN_OFF_CYC = 4,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             below_reg,
  input  logic             hs_over_limit,
  input  logic             il_zero_cross,
  input  logic [CNT_W-1:0] count,
  output logic             restart,
  output logic             hs_gate,
  output logic             ls_gate,
  output logic             sw_hiz
);
  import hbc_pkg::*;

  hbc_phase_e phase_q, phase_d;
  logic       zc_seen_q;
  logic       on_done, off_done, end_on, start_on;

  assign on_done  = interval_done(int'(count), MIN_ON_CYC);
  assign off_done = interval_done(int'(count), MIN_OFF_CYC);
  assign end_on   = hs_over_limit || (on_done && !below_reg);
  assign start_on = off_done && below_reg;

  always_comb begin
    phase_d = phase_q;
    if (halt) phase_d = PH_HIZ;
    else begin
      unique case (phase_q)
        PH_HIZ:     phase_d = PH_GAP_OFF;
        PH_ON:      if (end_on) phase_d = PH_GAP_OFF;
        PH_GAP_OFF: phase_d = PH_OFF;
        PH_OFF:     if (start_on) phase_d = PH_GAP_ON;
        PH_GAP_ON:  phase_d = PH_ON;
        default:    phase_d = PH_HIZ;
      endcase
    end
  end

  assign restart = (phase_d != phase_q) &&
                   ((phase_d == PH_ON) || (phase_d == PH_GAP_OFF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_HIZ;
      zc_seen_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      zc_seen_q <= (phase_q == PH_OFF && phase_d == PH_OFF) ?
                   (zc_seen_q || il_zero_cross) : 1'b0;
    end
  end

  assign hs_gate = (phase_q == PH_ON);
  assign ls_gate = (phase_q == PH_OFF) && !zc_seen_q;
  assign sw_hiz  = (phase_q == PH_HIZ);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  a_r2_dead_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |=> !ls_gate);

  a_r7_dead_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gate |=> !hs_gate);

  a_r4_min_on: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && !on_done && !hs_over_limit && !halt) |=> hs_gate);

  a_r3_min_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OFF && !off_done && !halt) |=> !hs_gate);

  a_r5_limit_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && hs_over_limit) |=> !hs_gate);

  a_r6_zc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OFF && il_zero_cross) |=> !ls_gate);

  a_r8_float: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (sw_hiz && !hs_gate && !ls_gate));

endmodule

// File: rtl/hyst_buck_ctrl.sv
module hyst_buck_ctrl #(
  parameter int unsigned MIN_ON_CYC  = 4,
  parameter int unsigned MIN_OFF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic below_reg,
  input  logic hs_over_limit,
  input  logic il_zero_cross,
  input  logic thermal_trip,
  input  logic thermal_cooled,
  output logic hs_gate,
  output logic ls_gate,
  output logic sw_hiz
);
  import hbc_pkg::*;

  localparam int unsigned SAT_VAL = larger(MIN_ON_CYC, MIN_OFF_CYC);
  localparam int unsigned CNT_W   = $clog2(SAT_VAL + 1) + 1;

  logic             fault_q;
  logic             halt;
  logic             restart;
  logic [CNT_W-1:0] count;

  assign halt = !enable || thermal_trip || fault_q;

  hbc_thermal_guard u_thermal (
    .clk            (clk),
    .rst_n          (rst_n),
    .thermal_trip   (thermal_trip),
    .thermal_cooled (thermal_cooled),
    .fault_q        (fault_q)
  );

  hbc_phase_timer #(.CNT_W(CNT_W), .SAT_VAL(SAT_VAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .count   (count)
  );

  hbc_phase_fsm #(
    .MIN_ON_CYC  (MIN_ON_CYC),
    .MIN_OFF_CYC (MIN_OFF_CYC),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt          (halt),
    .below_reg     (below_reg),
    .hs_over_limit (hs_over_limit),
    .il_zero_cross (il_zero_cross),
    .count         (count),
    .restart       (restart),
    .hs_gate       (hs_gate),
    .ls_gate       (ls_gate),
    .sw_hiz        (sw_hiz)
  );

  a_r10_cooled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_q && !thermal_trip) |=> !fault_q);

endmodule

// File: tb/hyst_buck_ctrl_test.sv
module hyst_buck_ctrl_test;
  localparam int MON = 4;
  localparam int MOFF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, below = 0, lim = 0, zc = 0, trip = 0, cool = 0;
  logic hs, ls, hiz;
  int checks = 0, errors = 0, cycles = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  hyst_buck_ctrl #(.MIN_ON_CYC(MON), .MIN_OFF_CYC(MOFF)) uut (
    .clk(clk), .rst_n(rst_n), .enable(en), .below_reg(below),
    .hs_over_limit(lim), .il_zero_cross(zc), .thermal_trip(trip),
    .thermal_cooled(cool), .hs_gate(hs), .ls_gate(ls), .sw_hiz(hiz));

  // Reference model: mode 0 float, 1 pulse, 2 gap after pulse, 3 off, 4 gap before pulse
  int mode = 0, t_on = 0, t_off = 0;
  bit m_zc = 0, m_fault = 0;

  always @(posedge clk) begin
    bit stop;
    int nxt;
    if (!rst_n) begin
      mode = 0; m_zc = 0; m_fault = 0;
    end else begin
      stop = !en || trip || m_fault;
      m_fault = trip ? 1'b1 : (cool ? 1'b0 : m_fault);
      nxt = mode;
      if (stop) nxt = 0;
      else if (mode == 0) begin nxt = 2; t_off = 1; end
      else if (mode == 1) begin
        if (lim || (t_on >= MON && !below)) begin nxt = 2; t_off = 1; end
        else t_on++;
      end
      else if (mode == 2) begin nxt = 3; t_off++; end
      else if (mode == 3) begin
        if (t_off >= MOFF && below) nxt = 4; else t_off++;
      end
      else begin nxt = 1; t_on = 1; end
      m_zc = (mode == 3 && nxt == 3) ? (m_zc | zc) : 1'b0;
      mode = nxt;
    end
  end

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d",
               req, what, act, exp, cycles);
    end
  endtask

  // Per-cycle model comparison and run-length monitors
  bit prev_hs = 0, prev_ls = 0, exempt = 0, hiz_seen = 1;
  int hi_run = 0, lo_run = 0;
  always @(negedge clk) begin
    if (model_on) begin
      check("R3/R4/R5", "hs_gate vs model", hs, mode == 1);
      check("R6/R7", "ls_gate vs model", ls, mode == 3 && !m_zc);
      check("R8/R9", "sw_hiz vs model", hiz, mode == 0);
      check("R2", "overlap", hs && ls, 1'b0);
      if (hs && prev_ls) check("R7", "ls high before hs rise", 1'b1, 1'b0);
      if (ls && prev_hs) check("R2", "hs high before ls rise", 1'b1, 1'b0);
      if (hs) begin
        if (!prev_hs) begin
          if (!hiz_seen) begin
            checks++;
            if (lo_run < MOFF + 1) begin
              errors++;
              $display("FAIL R3 gap length: actual %0d expected >= %0d", lo_run, MOFF + 1);
            end
          end
          hi_run = 0; exempt = 0;
        end
        hi_run++;
        if (lim || !en || trip || m_fault) exempt = 1;
      end else begin
        if (prev_hs) begin
          if (!exempt) begin
            checks++;
            if (hi_run < MON) begin
              errors++;
              $display("FAIL R4 pulse length: actual %0d expected >= %0d", hi_run, MON);
            end
          end
          lo_run = 0; hiz_seen = 0;
        end
        lo_run++;
        if (hiz) hiz_seen = 1;
      end
    end
    prev_hs = hs; prev_ls = ls;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    check("R1", "sw_hiz after reset", hiz, 1'b1);
    check("R1", "hs_gate after reset", hs, 1'b0);
    check("R1", "ls_gate after reset", ls, 1'b0);
    rst_n = 1; model_on = 1;
    cyc(3);
    check("R8", "float while disabled", hiz, 1'b1);

    // R8: enable, first cycle both gates low and not floating
    en = 1; below = 0;
    cyc(1);
    check("R8", "leave float", hiz, 1'b0);
    check("R6", "gap ls", ls, 1'b0);
    cyc(1);
    check("R6", "rectifier on", ls, 1'b1);
    zc = 1; cyc(1); zc = 0;
    check("R6", "rectifier cut", ls, 1'b0);
    cyc(3);
    check("R6", "rectifier stays cut", ls, 1'b0);

    // R3/R7: below sampled with off interval done -> gap, then pulse
    below = 1; cyc(1);
    check("R7", "gap before pulse ls", ls, 1'b0);
    check("R7", "gap before pulse hs", hs, 1'b0);
    cyc(1);
    check("R3", "pulse starts", hs, 1'b1);
    // R5: limit on first pulse cycle
    lim = 1; cyc(1); lim = 0;
    check("R5", "limit ends pulse early", hs, 1'b0);
    below = 0; cyc(8);

    // R4: pulse held by minimum on interval
    below = 1; cyc(2); below = 0;
    check("R4", "pulse active", hs, 1'b1);
    cyc(2);
    check("R4", "min on holds", hs, 1'b1);
    cyc(6);

    // R10: cooled with no fault
    cool = 1; cyc(1); cool = 0;
    check("R10", "cooled ignored", hiz, 1'b0);

    // R9: thermal trip and recovery
    below = 1;
    trip = 1; cyc(1); trip = 0;
    check("R9", "trip floats", hiz, 1'b1);
    cyc(10);
    check("R9", "fault held", hiz, 1'b1);
    cool = 1; cyc(1); cool = 0;
    check("R9", "one cycle after cooled", hiz, 1'b1);
    cyc(1);
    check("R9", "resume after cooled", hiz, 1'b0);

    // R8: disable mid-run
    cyc(5);
    en = 0; cyc(1);
    check("R8", "disable floats", hiz, 1'b1);
    check("R8", "disable hs", hs, 1'b0);
    en = 1; cyc(2);

    // Random stretch, model compared every cycle
    for (int i = 0; i < 6000; i++) begin
      below = ($urandom_range(0, 2) != 0);
      zc    = ($urandom_range(0, 5) == 0);
      lim   = ($urandom_range(0, 40) == 0);
      trip  = ($urandom_range(0, 400) == 0);
      cool  = ($urandom_range(0, 6) == 0);
      en    = ($urandom_range(0, 300) != 0);
      cyc(1);
    end
    finish_run();
  end
endmodule